// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. On a load cycle it captures an external start address and the transfer direction. On each following advance cycle it steps a two-bit beat counter. The two low address bits are then re-derived from the captured start bits in one of two orders. The upper address bits come from the captured address and stay fixed for the whole burst.

A static order input picks the sequence. When it is high, which is also the default, the order is XOR-interleaved. When it is low, the order is a linear count that wraps at four. An active-low clock enable freezes all internal state for any cycle in which it is sampled high.

The address and direction interfaces are control paths rather than data streams, so the block has no valid/ready handshake. The outputs come straight from registered state, and each edge that is enabled makes one beat take effect.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and on the first sample after it is released, `beat_addr` is all zeros and `dir_q` is 0.
- R2: On a rising edge with `cke_n`=0 and `adv_ld`=0, the block captures `ext_addr` and `dir_in`. Immediately after that edge, `beat_addr` equals the captured `ext_addr` in full, in either order mode.
- R3: With `order_sel`=1 (interleaved), the low two bits of `beat_addr` on beats 0 to 3 after a load with start bits S are S, S^01, S^10, S^11.
- R4: With `order_sel`=0 (linear), the low two bits on beats 0 to 3 are S, S+1, S+2, S+3, each taken modulo 4.
- R5: A fifth beat, which is the fourth advance after a load, returns the low two bits to S. No carry reaches bit 2 or any higher bit.
- R6: During advance cycles, bits [AW-1:2] of `beat_addr` keep the value captured at the load.
- R7: `dir_q` takes `dir_in` only on load edges and ignores `dir_in` on advance edges.
- R8: On an edge with `cke_n`=1, `beat_addr` and `dir_q` stay unchanged, whatever `adv_ld`, `ext_addr` and `dir_in` are.
- R9: A load that comes before a burst has finished restarts the sequence at the new start address, at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_n | input | 1 | Active-low clock enable; when it is 1 the state holds |
| adv_ld | input | 1 | 1 = advance the beat counter, 0 = load a new start |
| ext_addr | input | AW | External start address, captured on load |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; static |
| dir_in | input | 1 | Burst direction, sampled on load only |
| beat_addr | output | AW | Address of the current beat |
| dir_q | output | 1 | Direction captured at the last load |

## Verification
The bench runs a full burst from every start value in both orders, with a fifth beat added to each. A design that carried into bit 2 or kept counting past four beats would corrupt the upper bits or fail to return to the start. It toggles `dir_in` throughout each burst, which catches a direction register that still follows its input on advance cycles. It also stalls in mid-burst while presenting a new load pattern, so that a clock enable that did not gate every register would show up as a jump in the address. Finally, it loads again in mid-burst and expects beat 0 of the new start, which shows whether the counter is cleared on a load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int W = BEAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (en) begin
      if (restart)     cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart) |=> (cnt == W'($past(cnt) + 1'b1)));
  p_ctr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> (cnt == '0));
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
#(
  parameter int W = BEAT_W
) (
  input  logic [W-1:0] start,
  input  logic [W-1:0] cnt,
  input  order_e       mode,
  output logic [W-1:0] low
);
  logic [W-1:0] xor_low;
  logic [W-1:0] lin_low;

  for (genvar b = 0; b < W; b++) begin : g_xor
    assign xor_low[b] = start[b] ^ cnt[b];
  end

  assign lin_low = start + cnt;

  always_comb begin
    if (mode == ORD_XOR) low = xor_low;
    else                 low = lin_low;
  end

  always_comb begin
    if (cnt == '0) p_beat0_start_r2: assert (low == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          adv_ld,
  input  logic [AW-1:0] ext_addr,
  input  logic          order_sel,
  input  logic          dir_in,
  output logic [AW-1:0] beat_addr,
  output logic          dir_q
);
  localparam int UW = AW - BEAT_W;

  logic              en;
  logic              do_load;
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] low;
  order_e            mode;

  assign en      = !cke_n;
  assign do_load = en && !adv_ld;
  assign mode    = order_sel ? ORD_XOR : ORD_LINEAR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      dir_q  <= 1'b0;
    end else if (do_load) begin
      base_q <= ext_addr;
      dir_q  <= dir_in;
    end
  end

  burst_beat_ctr #(.W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (!adv_ld),
    .cnt     (cnt)
  );

  burst_order #(.W(BEAT_W)) u_ord (
    .start (base_q[BEAT_W-1:0]),
    .cnt   (cnt),
    .mode  (mode),
    .low   (low)
  );

  assign beat_addr = {base_q[AW-1:BEAT_W], low};

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (beat_addr == $past(ext_addr)));
  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld) |=> (beat_addr[AW-1:BEAT_W] == $past(beat_addr[AW-1:BEAT_W])));
  p_dir_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld) |=> $stable(dir_q));
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(dir_q) && $stable(beat_addr[AW-1:BEAT_W])));
  p_reset_val_r1: assert property (@(posedge clk)
    !rst_n |=> (beat_addr == '0 && dir_q == 1'b0));

  localparam int UNUSED_UW = UW;
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 16;
  localparam time CLK_P = 10ns;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cke_n = 0;
  logic          adv_ld = 0;
  logic [AW-1:0] ext_addr = '0;
  logic          order_sel = 1;
  logic          dir_in = 0;
  logic [AW-1:0] beat_addr;
  logic          dir_q;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          dir;
    string         tag;
  } exp_t;
  exp_t q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_dir = 0;
  bit            done = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld),
    .ext_addr(ext_addr), .order_sel(order_sel), .dir_in(dir_in),
    .beat_addr(beat_addr), .dir_q(dir_q)
  );

  function automatic logic [AW-1:0] model_addr(input logic sel);
    logic [1:0] s;
    logic [1:0] lo;
    s = m_base[1:0];
    if (sel) lo = s ^ m_beat;         // R3 interleave
    else     lo = 2'((s + m_beat) % 4); // R4 linear
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic step(input logic stall, input logic adv,
                      input logic [AW-1:0] a, input logic d, input string tag);
    exp_t e;
    @(negedge clk);
    cke_n = stall; adv_ld = adv; ext_addr = a; dir_in = d;
    @(posedge clk);
    if (!stall) begin
      if (!adv) begin m_base = a; m_beat = 0; m_dir = d; end
      else m_beat = m_beat + 1'b1;
    end
    e.addr = model_addr(order_sel);
    e.dir  = m_dir;
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (beat_addr !== e.addr || dir_q !== e.dir) begin
          n_bad++;
          $display("FAIL %s: addr=%h dir=%b expected addr=%h dir=%b",
                   e.tag, beat_addr, dir_q, e.addr, e.dir);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    n_chk++;
    if (beat_addr !== '0 || dir_q !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: addr=%h dir=%b expected addr=0 dir=0", beat_addr, dir_q);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #(CLK_P/4);
    n_chk++;
    if (beat_addr !== '0 || dir_q !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: addr=%h dir=%b expected addr=0 dir=0", beat_addr, dir_q);
    end

    // Full bursts from every start in both orders, five beats each (R5 wrap)
    for (int m = 1; m >= 0; m--) begin
      @(negedge clk); order_sel = m[0];
      for (int s = 0; s < 4; s++) begin
        a = 16'hA5C0 ^ AW'(s * 16'h0110) | AW'(s);
        step(0, 0, a, s[0], "R2");
        for (int k = 1; k <= 4; k++)
          step(0, 1, ~a, ~s[0] ^ k[0], (k == 4) ? "R5/R6/R7" :
               (m == 1 ? "R3/R6/R7" : "R4/R6/R7"));
      end
    end

    // Stall mid-burst while a different load is presented (R8)
    @(negedge clk); order_sel = 1;
    step(0, 0, 16'h3C02, 1, "R2");
    step(0, 1, 16'h0, 0, "R3");
    step(1, 0, 16'hFFFD, 0, "R8");
    step(1, 1, 16'h1234, 0, "R8");
    step(0, 1, 16'h0, 0, "R3/R8");
    step(0, 1, 16'h0, 0, "R3");

    // Reload before the burst completes (R9), linear order
    @(negedge clk); order_sel = 0;
    step(0, 0, 16'h7781, 0, "R2");
    step(0, 1, 16'h0, 1, "R4");
    step(0, 0, 16'h0E43, 1, "R9");
    step(0, 1, 16'h0, 0, "R9/R4");
    step(0, 1, 16'h0, 0, "R9/R4");
    step(1, 1, 16'h0, 0, "R8");

    @(posedge clk); #(CLK_P/2);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule